// File: doc/BRIEF.md
# Address-Steered AXI4 Width Upsizer

This block joins a 64-bit AXI4 manager to a wider AXI4 subordinate: 128, 256 or 512 bits, chosen by a parameter. It places each narrow write beat's data and strobes in the wide-word byte lanes that the beat's own address selects. It also returns each narrow read beat from the lanes that the beat address selects. The beat address starts at the AW or AR address and advances by the transfer size on every beat. Lane choice therefore never depends on the beat's position in the burst.

Consecutive narrow write beats that fall in the same wide word are merged into one wide beat. A wide beat is emitted when the next beat address crosses a wide-word boundary or when the burst ends. Reads mirror this: a wide R beat is held until the narrow side has consumed every beat that lies inside it. Small unaligned DMA-style accesses therefore touch only their own bytes. Cache-line bursts fill successive lanes of each wide beat.

The manager side sees INCR bursts only; every burst is issued as INCR on the wide side. One write burst and one read burst are steered at a time. Write responses pass straight back.

Top module: `axi_lane_upsizer`

## Requirements
- R1: Each narrow write beat lands in wide lane `addr[log2(WIDE_W/8)-1:3]` of its beat address. The beat address starts at AW address and increases by 2^size per beat. The wide beat address is that address rounded down to a wide word.
- R2: A wide write strobe bit is set only for bytes that a narrow strobe inside that wide word set. A single narrow beat of 2^size bytes at address a gives wide strobe `((1<<2^size)-1) << a[log2(WIDE_W/8)-1:0]`. A wide beat never merges more narrow beats than it has bytes.
- R3: Each narrow read beat returns the 64-bit lane of the current wide R data selected by its beat address bits `[log2(WIDE_W/8)-1:3]`.
- R4: A single-beat request (len 0) is forwarded with len 0 and its own size unchanged.
- R5: A multi-beat request is forwarded with size log2(WIDE_W/8) and len = ((start + len·2^size) >> log2(WIDE_W/8)) − (start >> log2(WIDE_W/8)). The start address is passed unchanged and the burst type is INCR (2'b01).
- R6: The wide R beat is consumed only on a narrow beat whose next address crosses a wide-word boundary, or on the last narrow beat. A read burst thus takes exactly wide len + 1 wide beats.
- R7: Narrow RLAST is high exactly on beat number len of the narrow burst. RID and RRESP come from the wide side unchanged.
- R8: Write responses (BID, BRESP, handshake) pass between the two sides unchanged.
- R9: The W-channel ID, destination and user fields pass from narrow to wide unchanged.
- R10: W beats are accepted only once their AW has been accepted. A new AW (or AR) is accepted only after the previous write (or read) burst's last narrow beat.
- R11: Out of reset no wide AW, W or AR request and no narrow B or R response is valid, and W is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awid | input | ID_W | Narrow write ID |
| s_awaddr | input | ADDR_W | Narrow write address |
| s_awlen | input | 8 | Narrow write beats minus one |
| s_awsize | input | 3 | Narrow write beat size (≤3) |
| s_awvalid | input | 1 | Narrow AW valid |
| s_awready | output | 1 | Narrow AW ready |
| s_wdata | input | 64 | Narrow write data |
| s_wstrb | input | 8 | Narrow write strobes |
| s_wlast | input | 1 | Last narrow write beat |
| s_wid | input | ID_W | W sideband ID |
| s_wdest | input | DEST_W | W sideband destination |
| s_wuser | input | USER_W | W sideband user |
| s_wvalid | input | 1 | Narrow W valid |
| s_wready | output | 1 | Narrow W ready |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_arid | input | ID_W | Narrow read ID |
| s_araddr | input | ADDR_W | Narrow read address |
| s_arlen | input | 8 | Narrow read beats minus one |
| s_arsize | input | 3 | Narrow read beat size (≤3) |
| s_arvalid | input | 1 | Narrow AR valid |
| s_arready | output | 1 | Narrow AR ready |
| s_rid | output | ID_W | Read ID |
| s_rdata | output | 64 | Narrow read data |
| s_rresp | output | 2 | Read response |
| s_rlast | output | 1 | Last narrow read beat |
| s_rvalid | output | 1 | Narrow R valid |
| s_rready | input | 1 | Narrow R ready |
| m_awid | output | ID_W | Wide write ID |
| m_awaddr | output | ADDR_W | Wide write address |
| m_awlen | output | 8 | Wide write beats minus one |
| m_awsize | output | 3 | Wide write size |
| m_awburst | output | 2 | Wide burst type (INCR) |
| m_awvalid | output | 1 | Wide AW valid |
| m_awready | input | 1 | Wide AW ready |
| m_wdata | output | WIDE_W | Wide write data |
| m_wstrb | output | WIDE_W/8 | Wide write strobes |
| m_wlast | output | 1 | Last wide write beat |
| m_wid | output | ID_W | W sideband ID |
| m_wdest | output | DEST_W | W sideband destination |
| m_wuser | output | USER_W | W sideband user |
| m_wvalid | output | 1 | Wide W valid |
| m_wready | input | 1 | Wide W ready |
| m_bid | input | ID_W | Wide response ID |
| m_bresp | input | 2 | Wide write response |
| m_bvalid | input | 1 | Wide response valid |
| m_bready | output | 1 | Wide response ready |
| m_arid | output | ID_W | Wide read ID |
| m_araddr | output | ADDR_W | Wide read address |
| m_arlen | output | 8 | Wide read beats minus one |
| m_arsize | output | 3 | Wide read size |
| m_arburst | output | 2 | Wide burst type (INCR) |
| m_arvalid | output | 1 | Wide AR valid |
| m_arready | input | 1 | Wide AR ready |
| m_rid | input | ID_W | Wide read ID |
| m_rdata | input | WIDE_W | Wide read data |
| m_rresp | input | 2 | Wide read response |
| m_rlast | input | 1 | Wide last read beat |
| m_rvalid | input | 1 | Wide R valid |
| m_rready | output | 1 | Wide R ready |

## Verification
The assertions assume a well-behaved manager on the narrow side. It issues INCR bursts of size at most 8 bytes, with addresses aligned to that size. It marks the final W beat of each burst with WLAST and sends exactly len + 1 beats. They also assume a subordinate that returns the wide beat count it was asked for and raises RLAST on the final one. The bench keeps to this: every vector uses a size-aligned address, the W loop drives WLAST on beat len, and the byte-memory subordinate model produces exactly len + 1 read beats. Byte offsets cover every lane of a 128-bit word, together with full-line and boundary-crossing bursts.

// File: rtl/axi_lane_upsizer.sv
module axi_lane_upsizer #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int DEST_W = 4,
  parameter int USER_W = 2,
  parameter int WIDE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   s_awid,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [7:0]        s_awlen,
  input  logic [2:0]        s_awsize,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [63:0]       s_wdata,
  input  logic [7:0]        s_wstrb,
  input  logic              s_wlast,
  input  logic [ID_W-1:0]   s_wid,
  input  logic [DEST_W-1:0] s_wdest,
  input  logic [USER_W-1:0] s_wuser,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [7:0]        s_arlen,
  input  logic [2:0]        s_arsize,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [ID_W-1:0]   s_rid,
  output logic [63:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ID_W-1:0]   m_awid,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [WIDE_W-1:0] m_wdata,
  output logic [WIDE_W/8-1:0] m_wstrb,
  output logic              m_wlast,
  output logic [ID_W-1:0]   m_wid,
  output logic [DEST_W-1:0] m_wdest,
  output logic [USER_W-1:0] m_wuser,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [ID_W-1:0]   m_bid,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic [ID_W-1:0]   m_arid,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [ID_W-1:0]   m_rid,
  input  logic [WIDE_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rlast,
  input  logic              m_rvalid,
  output logic              m_rready
);
  localparam int SB = WIDE_W / 8;
  localparam int WB = $clog2(SB);
  localparam int LW = WB - 3;
  localparam logic [2:0] WSIZE = 3'(WB);

  function automatic logic [ADDR_W-1:0] align(input logic [ADDR_W-1:0] a, input logic [2:0] sz);
    return a & ~((ADDR_W'(1) << sz) - ADDR_W'(1));
  endfunction

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a, input logic [2:0] sz);
    return align(a, sz) + (ADDR_W'(1) << sz);
  endfunction

  function automatic logic [7:0] wide_len(input logic [ADDR_W-1:0] a, input logic [7:0] len,
                                          input logic [2:0] sz);
    logic [ADDR_W-1:0] fin;
    fin = align(a, sz) + (ADDR_W'(len) << sz);
    return 8'((fin >> WB) - (a >> WB));
  endfunction

  // write side
  logic              w_act;
  logic [ADDR_W-1:0] w_addr, w_next;
  logic [2:0]        w_size;
  logic [WIDE_W-1:0] acc_d, put_d, put_m;
  logic [SB-1:0]     acc_s, put_s;
  logic [LW-1:0]     w_lane;
  logic              w_flush;

  assign w_lane  = w_addr[WB-1:3];
  assign w_next  = step(w_addr, w_size);
  assign w_flush = s_wlast || (w_next[WB-1:0] == '0);
  assign put_s   = SB'(s_wstrb) << (w_lane * 8);
  assign put_d   = WIDE_W'(s_wdata) << (w_lane * 64);

  for (genvar i = 0; i < SB; i++) begin : g_mask
    assign put_m[i*8 +: 8] = {8{put_s[i]}};
  end

  assign m_awid    = s_awid;
  assign m_awaddr  = s_awaddr;
  assign m_awlen   = wide_len(s_awaddr, s_awlen, s_awsize);
  assign m_awsize  = (s_awlen == 8'd0) ? s_awsize : WSIZE;
  assign m_awburst = 2'b01;
  assign m_awvalid = s_awvalid && !w_act;
  assign s_awready = m_awready && !w_act;

  assign m_wdata  = acc_d | (put_d & put_m);
  assign m_wstrb  = acc_s | put_s;
  assign m_wlast  = s_wlast;
  assign m_wid    = s_wid;
  assign m_wdest  = s_wdest;
  assign m_wuser  = s_wuser;
  assign m_wvalid = w_act && s_wvalid && w_flush;
  assign s_wready = w_act && (!w_flush || m_wready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_act  <= 1'b0;
      w_addr <= '0;
      w_size <= '0;
      acc_d  <= '0;
      acc_s  <= '0;
    end else begin
      if (s_awvalid && s_awready) begin
        w_act  <= 1'b1;
        w_addr <= s_awaddr;
        w_size <= s_awsize;
      end
      if (s_wvalid && s_wready) begin
        w_addr <= w_next;
        if (w_flush) begin
          acc_d <= '0;
          acc_s <= '0;
        end else begin
          acc_d <= m_wdata;
          acc_s <= m_wstrb;
        end
        if (s_wlast) w_act <= 1'b0;
      end
    end
  end

  assign s_bid    = m_bid;
  assign s_bresp  = m_bresp;
  assign s_bvalid = m_bvalid;
  assign m_bready = s_bready;

  // read side
  logic              r_act;
  logic [ADDR_W-1:0] r_addr, r_next;
  logic [2:0]        r_size;
  logic [7:0]        r_left;
  logic [LW-1:0]     r_lane;
  logic              r_end;

  assign r_lane = r_addr[WB-1:3];
  assign r_next = step(r_addr, r_size);
  assign r_end  = (r_left == 8'd0);

  assign m_arid    = s_arid;
  assign m_araddr  = s_araddr;
  assign m_arlen   = wide_len(s_araddr, s_arlen, s_arsize);
  assign m_arsize  = (s_arlen == 8'd0) ? s_arsize : WSIZE;
  assign m_arburst = 2'b01;
  assign m_arvalid = s_arvalid && !r_act;
  assign s_arready = m_arready && !r_act;

  assign s_rid    = m_rid;
  assign s_rresp  = m_rresp;
  assign s_rdata  = m_rdata[r_lane*64 +: 64];
  assign s_rlast  = r_end && m_rlast;
  assign s_rvalid = r_act && m_rvalid;
  assign m_rready = r_act && s_rready && (r_end || (r_next[WB-1:0] == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_act  <= 1'b0;
      r_addr <= '0;
      r_size <= '0;
      r_left <= '0;
    end else begin
      if (s_arvalid && s_arready) begin
        r_act  <= 1'b1;
        r_addr <= s_araddr;
        r_size <= s_arsize;
        r_left <= s_arlen;
      end
      if (s_rvalid && s_rready) begin
        r_addr <= r_next;
        r_left <= r_left - 8'd1;
        if (r_end) r_act <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/axi_lane_upsizer_chk.sv
module axi_lane_upsizer_chk #(
  parameter int SB = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       s_awvalid,
  input logic       s_awready,
  input logic [7:0] s_awlen,
  input logic [2:0] s_awsize,
  input logic       m_awvalid,
  input logic       m_awready,
  input logic [7:0] m_awlen,
  input logic [2:0] m_awsize,
  input logic       s_wvalid,
  input logic       s_wready,
  input logic       s_wlast,
  input logic       m_wvalid,
  input logic       m_wready,
  input logic       m_wlast,
  input logic       s_arvalid,
  input logic       s_arready,
  input logic [7:0] s_arlen,
  input logic       s_rvalid,
  input logic       s_rready,
  input logic       s_rlast
);
  logic [8:0] wcnt, rcnt, ncnt;
  logic [7:0] cap_awlen, cap_arlen;
  logic       w_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0; rcnt <= '0; ncnt <= '0;
      cap_awlen <= '0; cap_arlen <= '0; w_open <= 1'b0;
    end else begin
      if (m_awvalid && m_awready) cap_awlen <= m_awlen;
      if (m_wvalid && m_wready) wcnt <= m_wlast ? 9'd0 : wcnt + 9'd1;
      if (s_arvalid && s_arready) cap_arlen <= s_arlen;
      if (s_rvalid && s_rready) rcnt <= s_rlast ? 9'd0 : rcnt + 9'd1;
      if (s_wvalid && s_wready) ncnt <= (m_wvalid && m_wready) ? 9'd0 : ncnt + 9'd1;
      if (s_awvalid && s_awready) w_open <= 1'b1;
      else if (s_wvalid && s_wready && s_wlast) w_open <= 1'b0;
    end
  end

  // R5
  wlen_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && m_wready && m_wlast |-> wcnt == {1'b0, cap_awlen});
  // R7
  rlast_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && s_rready && s_rlast |-> rcnt == {1'b0, cap_arlen});
  // R2
  merge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && m_wready |-> ncnt < 9'(SB));
  // R4
  single_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_awvalid && s_awlen == 8'd0 |-> m_awlen == 8'd0 && m_awsize == s_awsize);
  // R10
  w_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_wvalid && s_wready |-> w_open);
endmodule

bind axi_lane_upsizer axi_lane_upsizer_chk #(.SB(WIDE_W/8)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awlen(s_awlen), .s_awsize(s_awsize),
  .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awlen(m_awlen), .m_awsize(m_awsize),
  .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wlast(s_wlast),
  .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wlast(m_wlast),
  .s_arvalid(s_arvalid), .s_arready(s_arready), .s_arlen(s_arlen),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rlast(s_rlast)
);

// File: tb/axi_lane_upsizer_bench.sv
`timescale 1ns/1ps
module axi_lane_upsizer_bench;
  localparam int ID_W = 4;
  localparam int WIDE = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [ID_W-1:0] s_awid = '0, s_wid = '0, s_bid, s_arid = '0, s_rid;
  logic [31:0] s_awaddr = '0, s_araddr = '0;
  logic [7:0] s_awlen = '0, s_arlen = '0, s_wstrb = '0;
  logic [2:0] s_awsize = '0, s_arsize = '0;
  logic s_awvalid = 0, s_awready, s_wlast = 0, s_wvalid = 0, s_wready, s_bvalid, s_bready = 0;
  logic s_arvalid = 0, s_arready, s_rlast, s_rvalid, s_rready = 0;
  logic [63:0] s_wdata = '0, s_rdata;
  logic [3:0] s_wdest = '0;
  logic [1:0] s_wuser = '0, s_bresp, s_rresp;

  logic [ID_W-1:0] m_awid, m_wid, m_bid = '0, m_arid, m_rid = '0;
  logic [31:0] m_awaddr, m_araddr;
  logic [7:0] m_awlen, m_arlen;
  logic [2:0] m_awsize, m_arsize;
  logic [1:0] m_awburst, m_arburst, m_bresp = '0, m_rresp = '0, m_wuser;
  logic m_awvalid, m_awready = 1, m_wlast, m_wvalid, m_wready = 1, m_bvalid = 0, m_bready;
  logic m_arvalid, m_arready = 1, m_rlast = 0, m_rvalid = 0, m_rready;
  logic [WIDE-1:0] m_wdata, m_rdata = '0;
  logic [WIDE/8-1:0] m_wstrb;
  logic [3:0] m_wdest;

  axi_lane_upsizer #(.ADDR_W(32), .ID_W(ID_W), .DEST_W(4), .USER_W(2), .WIDE_W(WIDE)) u_axi_lane_upsizer (
    .clk(clk), .rst_n(rst_n),
    .s_awid(s_awid), .s_awaddr(s_awaddr), .s_awlen(s_awlen), .s_awsize(s_awsize),
    .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast), .s_wid(s_wid), .s_wdest(s_wdest),
    .s_wuser(s_wuser), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bid(s_bid), .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_arid(s_arid), .s_araddr(s_araddr), .s_arlen(s_arlen), .s_arsize(s_arsize),
    .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rid(s_rid), .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast),
    .s_rvalid(s_rvalid), .s_rready(s_rready),
    .m_awid(m_awid), .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
    .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wid(m_wid), .m_wdest(m_wdest),
    .m_wuser(m_wuser), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bid(m_bid), .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_arid(m_arid), .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
    .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rid(m_rid), .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
    .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] mem [256];
  logic [7:0] refm [256];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // wide-side subordinate model over a byte memory
  logic [7:0] sw_base, sr_base;
  int sw_idx = 0, sr_idx = 0, sr_left = 0, sub_rcnt = 0;
  logic [ID_W-1:0] sw_id;
  logic [7:0] last_awlen, last_arlen;
  logic [2:0] last_awsize, last_arsize;
  logic [15:0] last_wstrb;
  logic [1:0] last_wuser;
  logic [3:0] last_wdest, last_wid;

  task automatic load_r();
    logic [7:0] wa;
    wa = 8'(((int'(sr_base) >> 4) + sr_idx) << 4);
    for (int j = 0; j < 16; j++) m_rdata[j*8 +: 8] = mem[8'(wa + 8'(j))];
    m_rlast = (sr_left == 0);
    m_rresp = 2'b01;
  endtask

  always begin
    logic aw_hs, w_hs, b_hs, ar_hs, r_hs, c_wlast;
    logic [31:0] c_awaddr, c_araddr;
    logic [7:0] c_awlen, c_arlen;
    logic [2:0] c_awsize, c_arsize;
    logic [ID_W-1:0] c_awid, c_arid, c_wid;
    logic [WIDE-1:0] c_wdata;
    logic [15:0] c_wstrb;
    logic [1:0] c_wuser;
    logic [3:0] c_wdest;
    @(negedge clk);
    aw_hs = m_awvalid && m_awready; c_awaddr = m_awaddr; c_awlen = m_awlen;
    c_awsize = m_awsize; c_awid = m_awid;
    w_hs = m_wvalid && m_wready; c_wdata = m_wdata; c_wstrb = m_wstrb; c_wlast = m_wlast;
    c_wuser = m_wuser; c_wdest = m_wdest; c_wid = m_wid;
    b_hs = m_bvalid && m_bready;
    ar_hs = m_arvalid && m_arready; c_araddr = m_araddr; c_arlen = m_arlen;
    c_arsize = m_arsize; c_arid = m_arid;
    r_hs = m_rvalid && m_rready;
    @(posedge clk); #1;
    if (aw_hs) begin
      sw_base = c_awaddr[7:0]; sw_idx = 0; sw_id = c_awid;
      last_awlen = c_awlen; last_awsize = c_awsize;
    end
    if (b_hs) m_bvalid = 0;
    if (w_hs) begin
      for (int j = 0; j < 16; j++)
        if (c_wstrb[j]) mem[8'(((int'(sw_base) >> 4) + sw_idx) * 16 + j)] = c_wdata[j*8 +: 8];
      last_wstrb = c_wstrb; last_wuser = c_wuser; last_wdest = c_wdest; last_wid = c_wid;
      sw_idx++;
      if (c_wlast) begin m_bvalid = 1; m_bid = sw_id; m_bresp = 2'b01; end
    end
    if (r_hs) begin
      sub_rcnt++;
      if (sr_left == 0) m_rvalid = 0;
      else begin sr_left--; sr_idx++; load_r(); end
    end
    if (ar_hs) begin
      sr_base = c_araddr[7:0]; sr_idx = 0; sr_left = int'(c_arlen); m_rid = c_arid;
      last_arlen = c_arlen; last_arsize = c_arsize; sub_rcnt = 0;
      m_rvalid = 1; load_r();
    end
  end

  function automatic int exp_wlen(input logic [7:0] a, input logic [1:0] sz, input logic [3:0] ln);
    int fin;
    fin = int'(a) + (int'(ln) << sz);
    return (fin >> 4) - (int'(a) >> 4);
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [1:0] sz, input logic [3:0] ln,
                          input logic [3:0] id, input logic [7:0] seed);
    int nb, bad;
    logic [ID_W-1:0] got_bid;
    logic [1:0] got_bresp;
    nb = 1 << sz;
    fork
      begin
        s_awid = id; s_awaddr = {24'd0, a}; s_awlen = {4'd0, ln}; s_awsize = {1'b0, sz};
        s_awvalid = 1;
        do @(negedge clk); while (!s_awready);
        @(posedge clk); #1 s_awvalid = 0;
      end
      begin
        for (int k = 0; k <= int'(ln); k++) begin
          logic [7:0] ak;
          ak = a + 8'(k * nb);
          for (int j = 0; j < 8; j++) s_wdata[j*8 +: 8] = 8'({ak[7:3], 3'b000} + 8'(j)) ^ seed;
          s_wstrb = 8'(((1 << nb) - 1) << ak[2:0]);
          for (int j = 0; j < 8; j++)
            if (s_wstrb[j]) refm[8'({ak[7:3], 3'b000} + 8'(j))] = s_wdata[j*8 +: 8];
          s_wlast = (k == int'(ln)); s_wid = id; s_wdest = ~id; s_wuser = id[1:0];
          s_wvalid = 1;
          do @(negedge clk); while (!s_wready);
          @(posedge clk); #1;
        end
        s_wvalid = 0; s_wlast = 0;
      end
      begin
        s_bready = 1;
        do @(negedge clk); while (!s_bvalid);
        got_bid = s_bid; got_bresp = s_bresp;
        @(posedge clk); #1 s_bready = 0;
      end
    join
    @(posedge clk); #2;
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) bad++;
    check(bad == 0, "R1", $sformatf("write a=%0h lane placement, bytes wrong", a), 128'(bad), 0);
    if (ln == 0) begin
      check(last_awlen == 0 && last_awsize == {1'b0, sz}, "R4", "single len/size",
            {last_awlen, 5'd0, last_awsize}, {8'd0, 5'd0, 1'b0, sz});
      check(last_wstrb == 16'(((1 << nb) - 1) << a[3:0]), "R2", "single beat wide strobe",
            128'(last_wstrb), 128'(16'(((1 << nb) - 1) << a[3:0])));
    end else
      check(int'(last_awlen) == exp_wlen(a, sz, ln) && last_awsize == 3'd4, "R5",
            "burst len/size", {last_awlen, 5'd0, last_awsize}, 128'({8'(exp_wlen(a, sz, ln)), 8'd4}));
    check(got_bid == id && got_bresp == 2'b01, "R8", "B id/resp", {got_bid, got_bresp}, {id, 2'b01});
    check(last_wuser == id[1:0] && last_wdest == ~id && last_wid == id, "R9", "W sideband",
          {last_wid, last_wdest, last_wuser}, {id, ~id, id[1:0]});
  endtask

  task automatic do_read(input logic [7:0] a, input logic [1:0] sz, input logic [3:0] ln,
                         input logic [3:0] id);
    int nb;
    nb = 1 << sz;
    fork
      begin
        s_arid = id; s_araddr = {24'd0, a}; s_arlen = {4'd0, ln}; s_arsize = {1'b0, sz};
        s_arvalid = 1;
        do @(negedge clk); while (!s_arready);
        @(posedge clk); #1 s_arvalid = 0;
      end
      begin
        s_rready = 1;
        for (int k = 0; k <= int'(ln); k++) begin
          logic [7:0] ak;
          logic [63:0] msk, expw;
          ak = a + 8'(k * nb);
          msk = '0; expw = '0;
          for (int j = 0; j < 8; j++)
            if (j >= int'(ak[2:0]) && j < int'(ak[2:0]) + nb) begin
              msk[j*8 +: 8] = 8'hFF;
              expw[j*8 +: 8] = refm[8'({ak[7:3], 3'b000} + 8'(j))];
            end
          do @(negedge clk); while (!s_rvalid);
          check((s_rdata & msk) == expw, "R3", $sformatf("read a=%0h beat %0d", a, k),
                128'(s_rdata & msk), 128'(expw));
          check(s_rlast == (k == int'(ln)), "R7", "rlast position", 128'(s_rlast),
                128'(k == int'(ln)));
          if (k == int'(ln))
            check(s_rid == id && s_rresp == 2'b01, "R7", "rid/rresp", {s_rid, s_rresp}, {id, 2'b01});
          @(posedge clk); #1;
        end
        s_rready = 0;
      end
    join
    @(posedge clk); #2;
    check(sub_rcnt == exp_wlen(a, sz, ln) + 1, "R6", "wide R beats consumed",
          128'(sub_rcnt), 128'(exp_wlen(a, sz, ln) + 1));
    if (ln != 0)
      check(int'(last_arlen) == exp_wlen(a, sz, ln) && last_arsize == 3'd4, "R5", "read burst len/size",
            {last_arlen, 5'd0, last_arsize}, 128'({8'(exp_wlen(a, sz, ln)), 8'd4}));
  endtask

  // addr[15:8] size[5:4] len[3:0]
  localparam logic [15:0] VEC [16] = '{
    16'h0020, 16'h0420, 16'h0820, 16'h0C20, 16'h1100, 16'h1700, 16'h1900, 16'h1F00,
    16'h1A10, 16'h1E10, 16'h2830, 16'h3030, 16'h4037, 16'h8832, 16'hC424, 16'hE215
  };

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'h5A; refm[i] = 8'(i) ^ 8'h5A; end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(!m_awvalid && !m_wvalid && !m_arvalid && !s_bvalid && !s_rvalid && !s_wready, "R11",
          "outputs idle after reset", {m_awvalid, m_wvalid, m_arvalid, s_bvalid, s_rvalid, s_wready}, 0);
    // R10 W without AW is held off
    @(posedge clk); #1 s_wvalid = 1; s_wlast = 1; s_wstrb = 8'hFF;
    @(negedge clk);
    check(!s_wready, "R10", "W ready before AW", 128'(s_wready), 0);
    @(posedge clk); #1 s_wvalid = 0; s_wlast = 0;
    @(posedge clk); #1;
    for (int v = 0; v < 16; v++) begin
      do_write(VEC[v][15:8], VEC[v][5:4], VEC[v][3:0], 4'(v), 8'(v * 29 + 51));
      do_read(VEC[v][15:8], VEC[v][5:4], VEC[v][3:0], 4'(15 - v));
    end
    // re-read the full line after neighbouring narrow writes
    do_write(8'h44, 2'd2, 4'd0, 4'd3, 8'hC3);
    do_read(8'h40, 2'd3, 4'd7, 4'd9);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule